// File: doc/BRIEF.md
# Supply-Monitor Reset Source Controller

This block is the digital control logic that sits beside a supply-voltage comparator in a small microcontroller. It keeps the monitor's enable and threshold bits and a reset-source selection bit. It gathers four reset causes into one system reset: a power-on event, a monitor trip, a software request and a flash access made while the monitor cannot protect it. It also records which cause started the current reset. The comparator, the regulator and the flash array are outside the block. They appear only as single-bit inputs: a trip level, a stabilized flag, a power-on pulse and a flash-operation strobe.

Software reaches the block through a two-register write bus. A power-on event restores the safe defaults. Every other reset leaves the settings as software last wrote them. Because of this, a monitor left at its high threshold while the supply sags keeps the chip in reset until a power-on event lowers the threshold. Flash operations are granted only while the monitor is enabled and stable.

Top module: `supmon_rst_ctrl`

## Requirements
- R1: A power-on event (`rst_n` low, or a one-cycle `por_i` pulse seen at a clock edge) sets monitor enable to 1, threshold to low (0) and source selection to 1. It asserts `sys_rst_o` and sets `cause_o` to 4'b0001. `por_i` takes priority over any write in the same cycle.
- R2: A write with `wr_sel_i`=0 loads `wr_data_i[0]` into monitor enable and `wr_data_i[1]` into the threshold (1 = high). A write with `wr_sel_i`=1 loads `wr_data_i[0]` into source selection. Writing 0 there deselects the monitor.
- R3: A write with `wr_sel_i`=1 and `wr_data_i[1]`=1 asserts `sys_rst_o` from the next clock edge and sets `cause_o` to 4'b0100. The request bit is not stored.
- R4: `trip_i` starts a reset with `cause_o`=4'b0010 only when the monitor is both enabled and selected. This holds whatever `stable_i` is, so selecting the monitor before it settles can reset the chip.
- R5: `flash_op_i` while the monitor is disabled or `stable_i` is low starts a reset with `cause_o`=4'b1000. `flash_ok_o` is high only while `flash_op_i`, monitor enable and `stable_i` are all high and no reset is active.
- R6: After the last clock edge at which any cause is active, `sys_rst_o` stays high for exactly `HOLD_CYCLES` (default 16) further edges.
- R7: Software, monitor and flash-error resets leave enable, threshold and selection unchanged. A disabled monitor stays disabled, and a monitor at the high threshold with `trip_i` held keeps `sys_rst_o` high until a power-on event.
- R8: Register writes are ignored while `sys_rst_o` is high.
- R9: `cause_o` is always one-hot. It is reloaded only when a reset starts from the idle state or on a power-on event. When causes coincide, the priority is power-on, then monitor, then software, then flash error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| por_i | input | 1 | Synchronous power-on event pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = monitor control, 1 = reset-source register |
| wr_data_i | input | 2 | Write data |
| trip_i | input | 1 | Comparator output, 1 = supply below threshold |
| stable_i | input | 1 | Monitor has settled after enabling |
| flash_op_i | input | 1 | Flash erase or write attempt |
| sys_rst_o | output | 1 | System reset |
| cause_o | output | 4 | One-hot cause: [0] power-on, [1] monitor, [2] software, [3] flash error |
| mon_en_o | output | 1 | Monitor enable |
| mon_hi_o | output | 1 | Monitor high-threshold select |
| mon_sel_o | output | 1 | Monitor selected as reset source |
| flash_ok_o | output | 1 | Flash operation granted |

## Verification
A table of single-cycle stimuli is applied from the idle state over combinations of enable, selection, stability, trip, flash strobe and software request. These tell apart a trip that is qualified from one that is not, and a protected flash access from an unprotected one. Vectors with several simultaneous causes show the flag priority. Directed sequences measure the exact hold length after a held trip. They also show that a high-threshold trip is released only by a power-on pulse, that a disabled monitor survives a software reset, that writes made during reset are dropped, and that power-on overrides a software flag.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int CAUSE_N = 4;

  typedef enum logic [1:0] {
    C_POR   = 2'd0,
    C_MON   = 2'd1,
    C_SW    = 2'd2,
    C_FLASH = 2'd3
  } cause_e;

  typedef logic [CAUSE_N-1:0] cause_vec_t;

  typedef struct packed {
    logic en;
    logic hi;
    logic sel;
  } mon_cfg_t;

  localparam mon_cfg_t CFG_POR = '{en: 1'b1, hi: 1'b0, sel: 1'b1};
endpackage

// File: rtl/supmon_rst_sync.sv
module supmon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/supmon_cfg_regs.sv
module supmon_cfg_regs
  import supmon_pkg::*;
#(
  parameter int WR_W    = 2,
  parameter int EN_BIT  = 0,
  parameter int HI_BIT  = 1,
  parameter int SEL_BIT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            por_i,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [WR_W-1:0] wr_data_i,
  input  logic            block_i,
  output mon_cfg_t        cfg_o
);
  mon_cfg_t cfg_q, cfg_d;
  logic     cfg_ld;
  logic     wr_ok;

  assign wr_ok  = wr_en_i && !block_i;
  assign cfg_ld = por_i || wr_ok;

  always_comb begin
    cfg_d = cfg_q;
    if (por_i) begin
      cfg_d = CFG_POR;
    end else if (wr_ok) begin
      if (!wr_sel_i) begin
        cfg_d.en = wr_data_i[EN_BIT];
        cfg_d.hi = wr_data_i[HI_BIT];
      end else begin
        cfg_d.sel = wr_data_i[SEL_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_POR;
    else if (cfg_ld) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/supmon_cause_merge.sv
module supmon_cause_merge
  import supmon_pkg::*;
(
  input  mon_cfg_t   cfg_i,
  input  logic       por_i,
  input  logic       trip_i,
  input  logic       stable_i,
  input  logic       flash_op_i,
  input  logic       sw_req_i,
  output cause_vec_t raw_o,
  output cause_vec_t pick_o,
  output logic       any_o
);
  logic mon_active;

  assign mon_active = cfg_i.en && stable_i;

  always_comb begin
    raw_o          = '0;
    raw_o[C_POR]   = por_i;
    raw_o[C_MON]   = cfg_i.en && cfg_i.sel && trip_i;
    raw_o[C_SW]    = sw_req_i;
    raw_o[C_FLASH] = flash_op_i && !mon_active;
  end

  // Lowest index wins: scan from the top so later hits override.
  always_comb begin
    pick_o = '0;
    for (int i = CAUSE_N - 1; i >= 0; i--) begin
      if (raw_o[i]) pick_o = cause_vec_t'(1) << i;
    end
  end

  assign any_o = |raw_o;
endmodule

// File: rtl/supmon_rst_hold.sv
module supmon_rst_hold
  import supmon_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_i,
  input  cause_vec_t pick_i,
  output logic       sys_rst_o,
  output cause_vec_t cause_o
);
  localparam logic [CNT_W-1:0] HOLD_V  = CNT_W'(HOLD_CYCLES);
  localparam cause_vec_t       POR_VEC = cause_vec_t'(1) << C_POR;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ld;
  cause_vec_t       flag_q;
  logic             flag_ld;
  logic             idle;

  assign idle    = (cnt_q == '0);
  assign cnt_ld  = any_i || !idle;
  assign flag_ld = any_i && (idle || pick_i[C_POR]);

  always_comb begin
    if (any_i) cnt_d = HOLD_V;
    else       cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= HOLD_V;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= POR_VEC;
    else if (flag_ld) flag_q <= pick_i;
  end

  assign sys_rst_o = !idle;
  assign cause_o   = flag_q;
endmodule

// File: rtl/supmon_rst_ctrl.sv
module supmon_rst_ctrl
  import supmon_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter int WR_W        = 2,
  localparam int SW_BIT     = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            por_i,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [WR_W-1:0] wr_data_i,
  input  logic            trip_i,
  input  logic            stable_i,
  input  logic            flash_op_i,
  output logic            sys_rst_o,
  output logic [CAUSE_N-1:0] cause_o,
  output logic            mon_en_o,
  output logic            mon_hi_o,
  output logic            mon_sel_o,
  output logic            flash_ok_o
);
  logic       rst_n_int;
  mon_cfg_t   cfg;
  cause_vec_t raw, pick, flags;
  logic       any_cause;
  logic       sw_req;
  logic       in_rst;

  supmon_rst_sync #(.STAGES(2)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  supmon_cfg_regs #(.WR_W(WR_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .por_i     (por_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .block_i   (in_rst),
    .cfg_o     (cfg)
  );

  assign sw_req = wr_en_i && wr_sel_i && wr_data_i[SW_BIT] && !in_rst;

  supmon_cause_merge u_merge (
    .cfg_i      (cfg),
    .por_i      (por_i),
    .trip_i     (trip_i),
    .stable_i   (stable_i),
    .flash_op_i (flash_op_i),
    .sw_req_i   (sw_req),
    .raw_o      (raw),
    .pick_o     (pick),
    .any_o      (any_cause)
  );

  supmon_rst_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .any_i     (any_cause),
    .pick_i    (pick),
    .sys_rst_o (in_rst),
    .cause_o   (flags)
  );

  logic unused_raw;
  assign unused_raw = ^raw;

  assign sys_rst_o  = in_rst;
  assign cause_o    = flags;
  assign mon_en_o   = cfg.en;
  assign mon_hi_o   = cfg.hi;
  assign mon_sel_o  = cfg.sel;
  assign flash_ok_o = flash_op_i && cfg.en && stable_i && !in_rst;
endmodule

// File: rtl/supmon_rst_ctrl_chk.sv
module supmon_rst_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_i,
  input logic       wr_en_i,
  input logic       wr_sel_i,
  input logic       sw_bit_i,
  input logic       trip_i,
  input logic       stable_i,
  input logic       flash_op_i,
  input logic       sys_rst_o,
  input logic [3:0] cause_o,
  input logic       mon_en_o,
  input logic       mon_hi_o,
  input logic       mon_sel_o
);
  AST_POR_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (mon_en_o && !mon_hi_o && mon_sel_o && sys_rst_o && cause_o == 4'b0001)); // R1

  AST_SW_STARTS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i && sw_bit_i && !sys_rst_o) |=> sys_rst_o); // R3

  AST_TRIP_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en_o && mon_sel_o && trip_i) |=> sys_rst_o); // R4

  AST_FLASH_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_op_i && !(mon_en_o && stable_i)) |=> sys_rst_o); // R5

  AST_CFG_FROZEN_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_o && !por_i) |=> $stable({mon_en_o, mon_hi_o, mon_sel_o})); // R8

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cause_o) == 1); // R9
endmodule

bind supmon_rst_ctrl supmon_rst_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .por_i      (por_i),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .sw_bit_i   (wr_data_i[1]),
  .trip_i     (trip_i),
  .stable_i   (stable_i),
  .flash_op_i (flash_op_i),
  .sys_rst_o  (sys_rst_o),
  .cause_o    (cause_o),
  .mon_en_o   (mon_en_o),
  .mon_hi_o   (mon_hi_o),
  .mon_sel_o  (mon_sel_o)
);

// File: tb/tb_supmon_rst_ctrl.sv
`timescale 1ns/1ps
module tb_supmon_rst_ctrl;
  localparam int HOLD = 16;

  logic       clk = 1'b0;
  logic       rst_n, por_i, wr_en_i, wr_sel_i, trip_i, stable_i, flash_op_i;
  logic [1:0] wr_data_i;
  logic       sys_rst_o, mon_en_o, mon_hi_o, mon_sel_o, flash_ok_o;
  logic [3:0] cause_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  supmon_rst_ctrl #(.HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .trip_i(trip_i),
    .stable_i(stable_i), .flash_op_i(flash_op_i), .sys_rst_o(sys_rst_o),
    .cause_o(cause_o), .mon_en_o(mon_en_o), .mon_hi_o(mon_hi_o),
    .mon_sel_o(mon_sel_o), .flash_ok_o(flash_ok_o)
  );

  // {en, sel, stable, trip, flash, sw, exp_rst, exp_cause[3:0], exp_ok}
  // exp_cause 0000 means the flags must not change.
  localparam logic [11:0] VEC [11] = '{
    12'b1_1_1_1_0_0_1_0010_0,  // R4 qualified trip
    12'b1_0_1_1_0_0_0_0000_0,  // R4 trip, not selected
    12'b0_1_1_1_0_0_0_0000_0,  // R4 trip, disabled
    12'b1_1_0_1_0_0_1_0010_0,  // R4 selected before stable
    12'b1_1_1_0_1_0_0_0000_1,  // R5 protected flash access
    12'b0_1_1_0_1_0_1_1000_0,  // R5 flash with monitor off
    12'b1_1_0_0_1_0_1_1000_0,  // R5 flash with monitor unstable
    12'b1_1_1_0_0_1_1_0100_0,  // R3 software reset
    12'b1_1_1_1_0_1_1_0010_0,  // R9 monitor beats software
    12'b0_0_1_0_1_1_1_0100_0,  // R9 software beats flash
    12'b0_0_1_0_0_0_0_0000_0   // R4 idle, nothing happens
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic sel, input logic [1:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    step();
    wr_en_i = 1'b0; wr_data_i = 2'b00;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] prev_cause;
    rst_n = 1'b0; por_i = 1'b0; wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = 2'b00;
    trip_i = 1'b0; stable_i = 1'b1; flash_op_i = 1'b0;
    steps(3);
    chk("R1 rst reset", {7'd0, sys_rst_o}, 8'd1);
    chk("R1 cause", {4'd0, cause_o}, 8'h01);
    chk("R1 cfg", {5'd0, mon_en_o, mon_hi_o, mon_sel_o}, 8'b101);
    rst_n = 1'b1;
    steps(HOLD + 3);
    chk("R6 released after power-on", {7'd0, sys_rst_o}, 8'd0);
    prev_cause = 4'b0001;

    // Vector table
    for (int k = 0; k < 11; k++) begin
      logic [11:0] v;
      v = VEC[k];
      wr(1'b0, {1'b0, v[11]});
      wr(1'b1, {1'b0, v[10]});
      stable_i = v[9]; trip_i = v[8]; flash_op_i = v[7];
      if (v[6]) begin
        wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = {1'b1, v[10]};
      end
      step();
      chk("R3/R4/R5 vector rst", {7'd0, sys_rst_o}, {7'd0, v[5]});
      chk("R9 vector cause", {4'd0, cause_o}, {4'd0, (v[4:1] == 4'b0) ? prev_cause : v[4:1]});
      chk("R5 vector grant", {7'd0, flash_ok_o}, {7'd0, v[0]});
      if (v[4:1] != 4'b0) prev_cause = v[4:1];
      wr_en_i = 1'b0; wr_data_i = 2'b00; stable_i = 1'b1; trip_i = 1'b0; flash_op_i = 1'b0;
      steps(HOLD + 2);
      chk("R6 vector release", {7'd0, sys_rst_o}, 8'd0);
    end

    // R6: exact hold after a held trip
    wr(1'b0, 2'b01);
    wr(1'b1, 2'b01);
    trip_i = 1'b1;
    steps(5);
    trip_i = 1'b0;
    steps(HOLD - 1);
    chk("R6 still held", {7'd0, sys_rst_o}, 8'd1);
    step();
    chk("R6 released exactly", {7'd0, sys_rst_o}, 8'd0);

    // R7: high threshold with sagging supply held until power-on
    wr(1'b0, 2'b11);
    chk("R2 high threshold", {6'd0, mon_en_o, mon_hi_o}, 8'b11);
    trip_i = 1'b1;
    step();
    chk("R4 high trip cause", {4'd0, cause_o}, 8'h02);
    steps(40);
    chk("R7 held in reset", {6'd0, sys_rst_o, mon_hi_o}, 8'b11);
    por_i = 1'b1;
    step();
    por_i = 1'b0; trip_i = 1'b0;
    chk("R1 por pulse cfg", {5'd0, mon_en_o, mon_hi_o, mon_sel_o}, 8'b101);
    chk("R1 por pulse cause", {4'd0, cause_o}, 8'h01);
    steps(HOLD + 1);
    chk("R7 released after power-on", {7'd0, sys_rst_o}, 8'd0);

    // R7/R8: disabled monitor survives a software reset; writes dropped
    wr(1'b0, 2'b00);
    wr(1'b1, 2'b11);
    chk("R3 sw cause", {3'd0, sys_rst_o, cause_o}, 8'h14);
    wr(1'b0, 2'b01);
    chk("R8 write ignored", {7'd0, mon_en_o}, 8'd0);
    steps(HOLD + 1);
    chk("R7 stays disabled", {5'd0, sys_rst_o, mon_en_o, mon_sel_o}, 8'b001);

    // R2: writing 0 to selection deselects
    wr(1'b0, 2'b01);
    wr(1'b1, 2'b00);
    chk("R2 deselect", {6'd0, mon_en_o, mon_sel_o}, 8'b10);
    trip_i = 1'b1;
    step();
    chk("R4 deselected trip", {7'd0, sys_rst_o}, 8'd0);
    trip_i = 1'b0;

    // R9: power-on overrides a software flag mid-reset
    wr(1'b1, 2'b10);
    chk("R9 sw first", {4'd0, cause_o}, 8'h04);
    por_i = 1'b1;
    step();
    por_i = 1'b0;
    chk("R9 por override", {4'd0, cause_o}, 8'h01);
    steps(HOLD + 1);
    chk("R9 release", {7'd0, sys_rst_o}, 8'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule